// File: doc/BRIEF.md
# Cascadable Bidirectional LCD Segment Driver Core

This block is the digital core of an 80-channel dot-matrix LCD segment driver. Its channels are split into two 40-channel halves. Each half has its own serial shift register, its own direction select, and a pair of serial pins, one at each end of the half. The direction select decides which pin of the pair is the input and which is the output. Serial pins that would be bidirectional on a pad are modelled here as a separate input, a separate output and an output enable for each pin.

A latch strobe copies all 80 shifted bits into an output latch. For every channel, the latched bit and a frame-alternation signal together pick one of four drive levels. Each level is given as a 2-bit code. The halves can be chained. Feeding the right-hand output of the lower half into the left-hand input of the upper half forms one 80-bit chain. Further devices can be chained from the upper half's right-hand output in the same way.

The shift clock and the latch strobe are treated as ordinary data inputs. Both are sampled on the rising edge of a fast system clock.

Top module: `lcdSegDriver`

## Requirements
- R1: An active-low asynchronous reset clears both shift registers and the output latch. While the latch is clear, every channel code is 01 when frameAlt is 0 and 10 when frameAlt is 1. Both serial outputs of each half read 0.
- R2: A half shifts by one place only on the system clock edge where shiftClk is sampled low after being sampled high on the previous edge. A rising edge of shiftClk, or shiftClk held at either level, moves no bits.
- R3: With dirSel[h]=0 (rightward), half h takes its new bit from leftIn[h] into its lowest channel. Every stored bit moves one channel up, and rightOut[h] carries the bit of the half's highest channel.
- R4: With dirSel[h]=1 (leftward), half h takes its new bit from rightIn[h] into its highest channel. Every stored bit moves one channel down, and leftOut[h] carries the bit of the half's lowest channel.
- R5: For each half, exactly one of the pin enables is high. rightOe[h] is high for dirSel[h]=0, and leftOe[h] is high for dirSel[h]=1.
- R6: On a system clock edge with latchStrobe high, the latch takes the present shift contents. With latchStrobe low, the latch and therefore the codes hold, whatever shifting takes place.
- R7: Channel c (0-based, 0..79; half 0 holds channels 0..39 and half 1 holds channels 40..79) drives driveCodes[2c+1:2c]. The mapping from latched bit d and frameAlt m is: d=0,m=0 gives 01; d=0,m=1 gives 10; d=1,m=0 gives 00; d=1,m=1 gives 11. Bit 2c+1 always equals frameAlt, and the codes follow frameAlt with no clock delay.
- R8: The halves shift independently under their own selects. With both selects at 0 and rightOut[0] fed to leftIn[1], 80 shifts load one 80-bit chain, in which the first bit shifted in ends at channel 79.
- R9: A change of dirSel between shifts does not reorder stored bits. Only the direction of later shifts changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every control input |
| rstN | input | 1 | Asynchronous active-low reset |
| shiftClk | input | 1 | Serial shift clock; a sampled falling edge shifts both halves |
| latchStrobe | input | 1 | Latch strobe; while high, the latch is loaded every clock edge |
| frameAlt | input | 1 | Frame-alternation signal used in code selection |
| dirSel | input | 2 | Direction select per half (0 rightward, 1 leftward) |
| leftIn | input | 2 | Serial input at the low-channel end of each half |
| rightIn | input | 2 | Serial input at the high-channel end of each half |
| leftOut | output | 2 | Lowest-channel bit of each half |
| rightOut | output | 2 | Highest-channel bit of each half |
| leftOe | output | 2 | Enable of the low-end pin as an output |
| rightOe | output | 2 | Enable of the high-end pin as an output |
| driveCodes | output | 160 | 2-bit drive-level code per channel |

## Verification
A shift takes effect on the second system clock edge after shiftClk is raised: one edge records the high level and the next sees it low. Serial outputs are therefore compared at the falling clock edge that follows that second rising edge. The latch loads on the single rising edge at which latchStrobe is high, and the codes are compared at the falling edge after it. A change of frameAlt reaches the codes with no register in between, so the bench compares them at the next falling edge. Every stimulus is applied at a falling edge, and every comparison waits for the stated number of rising edges.

// File: rtl/lcdSegPkg.sv
package lcdSegPkg;

  typedef struct packed {
    logic shiftEn;
    logic latchEn;
  } segStrobe_t;

  typedef enum logic [1:0] {
    DRV_TOP  = 2'b00,
    DRV_MIDH = 2'b01,
    DRV_MIDL = 2'b10,
    DRV_BOT  = 2'b11
  } drvLevel_e;

  function automatic drvLevel_e levelOf(input logic dataBit, input logic alt);
    unique case ({dataBit, alt})
      2'b11:   levelOf = DRV_BOT;
      2'b10:   levelOf = DRV_TOP;
      2'b01:   levelOf = DRV_MIDL;
      default: levelOf = DRV_MIDH;
    endcase
  endfunction

endpackage

// File: rtl/lcdSegCtrl.sv
module lcdSegCtrl
  import lcdSegPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       shiftClk,
  input  logic       latchStrobe,
  output segStrobe_t strobe
);

  logic shiftClkQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftClkQ <= 1'b0;
    else       shiftClkQ <= shiftClk;
  end

  always_comb begin
    strobe.shiftEn = shiftClkQ & ~shiftClk;
    strobe.latchEn = latchStrobe;
  end

endmodule

// File: rtl/lcdSegPath.sv
module lcdSegPath
  import lcdSegPkg::*;
#(
  parameter int HALF_W     = 40,
  parameter int NUM_HALVES = 2,
  localparam int CH_N      = HALF_W * NUM_HALVES
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  segStrobe_t            strobe,
  input  logic                  frameAlt,
  input  logic [NUM_HALVES-1:0] dirSel,
  input  logic [NUM_HALVES-1:0] leftIn,
  input  logic [NUM_HALVES-1:0] rightIn,
  output logic [NUM_HALVES-1:0] leftOut,
  output logic [NUM_HALVES-1:0] rightOut,
  output logic [NUM_HALVES-1:0] leftOe,
  output logic [NUM_HALVES-1:0] rightOe,
  output logic [2*CH_N-1:0]     driveCodes
);

  logic [CH_N-1:0] shiftBits;
  logic [CH_N-1:0] latchBits;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    logic [HALF_W-1:0] shReg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shReg <= '0;
      end else if (strobe.shiftEn) begin
        if (dirSel[h]) shReg <= {rightIn[h], shReg[HALF_W-1:1]};
        else           shReg <= {shReg[HALF_W-2:0], leftIn[h]};
      end
    end

    assign shiftBits[h*HALF_W +: HALF_W] = shReg;
    assign leftOut[h]  = shReg[0];
    assign rightOut[h] = shReg[HALF_W-1];
    assign leftOe[h]   = dirSel[h];
    assign rightOe[h]  = ~dirSel[h];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               latchBits <= '0;
    else if (strobe.latchEn) latchBits <= shiftBits;
  end

  for (genvar c = 0; c < CH_N; c++) begin : g_chan
    assign driveCodes[2*c +: 2] = levelOf(latchBits[c], frameAlt);
  end

endmodule

// File: rtl/lcdSegDriver.sv
module lcdSegDriver
  import lcdSegPkg::*;
#(
  parameter int HALF_W     = 40,
  parameter int NUM_HALVES = 2,
  localparam int CH_N      = HALF_W * NUM_HALVES
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  shiftClk,
  input  logic                  latchStrobe,
  input  logic                  frameAlt,
  input  logic [NUM_HALVES-1:0] dirSel,
  input  logic [NUM_HALVES-1:0] leftIn,
  input  logic [NUM_HALVES-1:0] rightIn,
  output logic [NUM_HALVES-1:0] leftOut,
  output logic [NUM_HALVES-1:0] rightOut,
  output logic [NUM_HALVES-1:0] leftOe,
  output logic [NUM_HALVES-1:0] rightOe,
  output logic [2*CH_N-1:0]     driveCodes
);

  segStrobe_t strobe;

  lcdSegCtrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .shiftClk    (shiftClk),
    .latchStrobe (latchStrobe),
    .strobe      (strobe)
  );

  lcdSegPath #(
    .HALF_W     (HALF_W),
    .NUM_HALVES (NUM_HALVES)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .frameAlt   (frameAlt),
    .dirSel     (dirSel),
    .leftIn     (leftIn),
    .rightIn    (rightIn),
    .leftOut    (leftOut),
    .rightOut   (rightOut),
    .leftOe     (leftOe),
    .rightOe    (rightOe),
    .driveCodes (driveCodes)
  );

endmodule

// File: rtl/lcdSegDriver_chk.sv
module lcdSegDriver_chk #(
  parameter int HALF_W     = 40,
  parameter int NUM_HALVES = 2,
  localparam int CH_N      = HALF_W * NUM_HALVES
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  shiftClk,
  input logic                  latchStrobe,
  input logic                  frameAlt,
  input logic [NUM_HALVES-1:0] dirSel,
  input logic [NUM_HALVES-1:0] leftOut,
  input logic [NUM_HALVES-1:0] rightOut,
  input logic [NUM_HALVES-1:0] leftOe,
  input logic [NUM_HALVES-1:0] rightOe,
  input logic [2*CH_N-1:0]     driveCodes
);

  logic scSeen;
  logic fallNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) scSeen <= 1'b0;
    else       scSeen <= shiftClk;
  end

  assign fallNow = scSeen & ~shiftClk;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_hchk
    assert_pin_enable_R5: assert property (@(posedge clk) disable iff (!rstN)
      $onehot({leftOe[h], rightOe[h]}) && (leftOe[h] == dirSel[h]));

    assert_no_shift_R2: assert property (@(posedge clk) disable iff (!rstN)
      !fallNow |=> ($stable(leftOut[h]) && $stable(rightOut[h])));
  end

  assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !latchStrobe |=> (!$stable(frameAlt) || $stable(driveCodes)));

  for (genvar c = 0; c < CH_N; c++) begin : g_cchk
    assert_code_frame_R7: assert property (@(posedge clk) disable iff (!rstN)
      driveCodes[2*c+1] == frameAlt);
  end

endmodule

bind lcdSegDriver lcdSegDriver_chk #(
  .HALF_W     (HALF_W),
  .NUM_HALVES (NUM_HALVES)
) chk (
  .clk         (clk),
  .rstN        (rstN),
  .shiftClk    (shiftClk),
  .latchStrobe (latchStrobe),
  .frameAlt    (frameAlt),
  .dirSel      (dirSel),
  .leftOut     (leftOut),
  .rightOut    (rightOut),
  .leftOe      (leftOe),
  .rightOe     (rightOe),
  .driveCodes  (driveCodes)
);

// File: tb/tb_lcdSegDriver.sv
module tb_lcdSegDriver;

  localparam int HW = 40;
  localparam int NH = 2;
  localparam int CN = HW * NH;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic shiftClk = 1'b0;
  logic latchStrobe = 1'b0;
  logic frameAlt = 1'b0;
  logic [NH-1:0] dirSel = '0;
  logic [NH-1:0] leftIn = '0;
  logic [NH-1:0] rightIn = '0;
  logic [NH-1:0] leftOut, rightOut, leftOe, rightOe;
  logic [2*CN-1:0] driveCodes;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lcdSegDriver dut (
    .clk(clk), .rstN(rstN), .shiftClk(shiftClk), .latchStrobe(latchStrobe),
    .frameAlt(frameAlt), .dirSel(dirSel), .leftIn(leftIn), .rightIn(rightIn),
    .leftOut(leftOut), .rightOut(rightOut), .leftOe(leftOe), .rightOe(rightOe),
    .driveCodes(driveCodes)
  );

  // {dirSel, frameAlt, channel pattern}
  localparam logic [82:0] VECS [4] = '{
    {2'b00, 1'b0, 80'h0123456789ABCDEF0F1E},
    {2'b11, 1'b1, 80'hFFFF0000FFFF0000AAAA},
    {2'b01, 1'b0, 80'h80000000018000000001},
    {2'b10, 1'b1, 80'h5A5A5A5A5A3C3C3C3C3C}
  };

  function automatic logic [2*CN-1:0] expCodes(input logic [CN-1:0] pat, input logic m);
    logic [2*CN-1:0] r;
    for (int c = 0; c < CN; c++) begin
      case ({pat[c], m})
        2'b00: r[2*c +: 2] = 2'b01;
        2'b01: r[2*c +: 2] = 2'b10;
        2'b10: r[2*c +: 2] = 2'b00;
        default: r[2*c +: 2] = 2'b11;
      endcase
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [2*CN-1:0] act,
                     input logic [2*CN-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // one shift: raise shiftClk, then drop it; shift lands on the second rising edge
  task automatic doShift(input logic [NH-1:0] lIn, input logic [NH-1:0] rIn);
    @(negedge clk);
    shiftClk = 1'b1; leftIn = lIn; rightIn = rIn;
    @(negedge clk);
    shiftClk = 1'b0;
    @(negedge clk);
  endtask

  task automatic doLatch();
    @(negedge clk);
    latchStrobe = 1'b1;
    @(negedge clk);
    latchStrobe = 1'b0;
  endtask

  task automatic loadHalves(input logic [CN-1:0] pat, input logic [NH-1:0] sel);
    @(negedge clk);
    dirSel = sel;
    for (int i = 0; i < HW; i++) begin
      logic [NH-1:0] l, r;
      for (int h = 0; h < NH; h++) begin
        int k;
        k = sel[h] ? i : HW - 1 - i;
        l[h] = sel[h] ? 1'b0 : pat[h*HW + k];
        r[h] = sel[h] ? pat[h*HW + k] : 1'b0;
      end
      doShift(l, r);
    end
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        finishRun();
      end
    end
  end

  initial begin
    logic [CN-1:0] pat, expPat;
    logic m;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(driveCodes == expCodes('0, 1'b0), "R1 reset codes m0", driveCodes, expCodes('0, 1'b0));
    chk({leftOut, rightOut} == '0, "R1 reset serial outs", {leftOut, rightOut}, '0);
    frameAlt = 1'b1;
    @(negedge clk);
    chk(driveCodes == expCodes('0, 1'b1), "R1 reset codes m1", driveCodes, expCodes('0, 1'b1));
    rstN = 1'b1;
    frameAlt = 1'b0;

    // vector table: R3/R4 loading, R5 enables, R6 latch, R7 mapping
    for (int v = 0; v < 4; v++) begin
      pat = VECS[v][79:0];
      m = VECS[v][80];
      loadHalves(pat, VECS[v][82:81]);
      for (int h = 0; h < NH; h++) begin
        if (VECS[v][81+h])
          chk(leftOut[h] == pat[h*HW], "R4 left serial out", leftOut[h], pat[h*HW]);
        else
          chk(rightOut[h] == pat[h*HW+HW-1], "R3 right serial out", rightOut[h], pat[h*HW+HW-1]);
      end
      chk(leftOe == VECS[v][82:81] && rightOe == ~VECS[v][82:81], "R5 pin enables",
          {leftOe, rightOe}, {VECS[v][82:81], ~VECS[v][82:81]});
      frameAlt = m;
      doLatch();
      chk(driveCodes == expCodes(pat, m), "R6 R7 latched codes", driveCodes, expCodes(pat, m));
      frameAlt = ~m;
      @(negedge clk);
      chk(driveCodes == expCodes(pat, ~m), "R7 frameAlt flip", driveCodes, expCodes(pat, ~m));
    end

    // R6: shifting without strobe leaves codes untouched
    pat = VECS[3][79:0];
    m = frameAlt;
    for (int i = 0; i < 5; i++) doShift('1, '1);
    chk(driveCodes == expCodes(pat, m), "R6 hold without strobe", driveCodes, expCodes(pat, m));

    // R9: direction change does not reorder stored bits
    pat = VECS[0][79:0];
    loadHalves(pat, 2'b00);
    @(negedge clk);
    dirSel = 2'b01;
    doShift(2'b00, 2'b01);
    expPat = {pat[78:40], 1'b0, 1'b1, pat[39:1]};
    doLatch();
    chk(driveCodes == expCodes(expPat, frameAlt), "R9 direction change", driveCodes,
        expCodes(expPat, frameAlt));

    // R2: only a falling shiftClk shifts
    @(negedge clk);
    dirSel = 2'b00;
    doShift(2'b00, 2'b00);
    chk(leftOut[0] == 1'b0, "R2 setup", leftOut[0], 1'b0);
    @(negedge clk);
    leftIn = 2'b01;
    shiftClk = 1'b1;
    repeat (3) @(negedge clk);
    chk(leftOut[0] == 1'b0, "R2 rising or high level no shift", leftOut[0], 1'b0);
    shiftClk = 1'b0;
    @(negedge clk);
    chk(leftOut[0] == 1'b1, "R2 falling edge shifts", leftOut[0], 1'b1);

    // R8: cascade two halves into one 80-bit chain
    pat = 80'hDEADBEEF0123CAFE5555;
    @(negedge clk);
    dirSel = 2'b00;
    for (int c = CN - 1; c >= 0; c--) doShift({rightOut[0], pat[c]}, 2'b00);
    doLatch();
    chk(driveCodes == expCodes(pat, frameAlt), "R8 cascaded chain", driveCodes,
        expCodes(pat, frameAlt));

    // R1: asynchronous reset mid-operation
    #2 rstN = 1'b0;
    #1;
    chk(driveCodes == expCodes('0, frameAlt), "R1 async reset clears", driveCodes,
        expCodes('0, frameAlt));
    chk({leftOut, rightOut} == '0, "R1 async reset serial", {leftOut, rightOut}, '0);

    finishRun();
  end

endmodule